// File: doc/BRIEF.md
# Extended State Restore Sequencer

This block reloads the x87 floating-point state and the SSE state of a processor core from a save area in memory. A restore begins with a one-cycle start pulse that carries a base address, a two-bit component request, the enabled-feature register and the mode flags. The block first checks the access conditions. It then reads the area header and, when SSE is selected, the MXCSR word. Every read is one aligned 16-byte beat on a simple read port with one request in flight. Only after all validation has passed does it drive load strobes, with data, for the register file that sits outside the block.

For each selected component, one header bit chooses the source. When the bit is set, the component is loaded from the area. When it is clear, the component is forced to its initial values. An exception leaves every register untouched: a failed check produces no load strobe at all. The block reports the end of a restore with a one-cycle done pulse or a one-cycle exception pulse with a cause code.

Top module: `ext_state_restore`

## Requirements
- R1: On start, the pre-checks are made in a fixed priority. `osxsave_en` low gives exception code 1. Otherwise `task_switched` high gives code 2. Otherwise a base address with any of bits 5:0 set gives code 3 (general protection). A failed pre-check makes no memory read.
- R2: The header is three 64-bit words at area offsets 512, 520 and 528. Bits 0 and 1 of the first word select memory (set) or initial values (clear) for x87 and SSE. Code 3 is raised when the first word has a bit set that is clear in `xcr0`, or when the second or third word is nonzero.
- R3: When SSE is selected, the 32-bit word at offset 24 is checked against the parameter `MXCSR_MASK` (default 0x0000FFBF). Any bit outside the mask raises code 3, even when header bit 1 is clear. When SSE is not selected, the word is not checked.
- R4: No load strobe is asserted between start and an exception. Done and exception never occur together, and each is a single-cycle pulse.
- R5: On an x87 load from memory, the following fields come from the 16 bytes at offset 0. `fcw` is bytes 0–1. `fsw` is bytes 2–3. `ftop` is `fsw[13:11]`. `fop` is the low 11 bits of bytes 6–7.
- R6: With `os64` high, `fip` is bytes 8–15 and `fdp` is bytes 16–23, and `fcs` and `fds` are zero. With `os64` low, `fip` and `fdp` are the zero-extended 32-bit words at bytes 8 and 16, `fcs` is bytes 12–13, and `fds` is bytes 20–21.
- R7: When x87 is selected and header bit 0 is clear, the block loads initial values: `fcw`=0x037F, and `fsw`, `fop`, the pointers and the selectors all zero. All eight FP registers are written with zero and the tag word is 0xFFFF.
- R8: The tag word is built from the abridged tag byte (byte 4 of offset 0), two bits per register `i`. If abridged bit `i` is clear, the pair is 2'b11. If it is set, the pair is 2'b01 for a zero exponent with a zero fraction. It is 2'b10 for an exponent of 0x7FFF, a zero exponent, or bit 63 of the fraction clear. It is 2'b00 otherwise. The tag is written once, after all FP registers.
- R9: On an x87 load, FP register `i` (0–7) takes the low 80 bits of the 16 bytes at offset 32+16·i, with exponent and sign in bits 79:64.
- R10: When SSE is selected, MXCSR is loaded with bytes 24–27. Then XMM register `i` is loaded from offset 160+16·i, or with zero if header bit 1 is clear. Registers 8–15 are written only when `long_mode` is high.
- R11: A component is selected only when both its `req_mask` bit and its `xcr0` bit are set. An unselected component gets no load strobe.
- R12: At most one read is outstanding. Every read address is 16-byte aligned and lies at the base plus the offsets listed above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a restore (sampled when idle) |
| base_addr | input | ADDR_W | Save area base address |
| req_mask | input | 2 | Requested components: bit 0 x87, bit 1 SSE |
| xcr0 | input | 64 | Enabled-feature register |
| osxsave_en | input | 1 | Save/restore instructions enabled by the OS |
| task_switched | input | 1 | Task-switched flag |
| os64 | input | 1 | 64-bit operand size |
| long_mode | input | 1 | 64-bit mode, enables XMM 8–15 |
| rd_req | output | 1 | Read request, one cycle |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 128 | Read data, byte 0 in bits 7:0 |
| ctrl_we | output | 1 | Control/status/opcode load strobe |
| fcw | output | 16 | Control word |
| fsw | output | 16 | Status word |
| ftop | output | 3 | Top of stack |
| fop | output | 11 | Last opcode |
| ptr_we | output | 1 | Pointer load strobe |
| fip | output | 64 | Instruction pointer |
| fcs | output | 16 | Instruction selector |
| fdp | output | 64 | Data pointer |
| fds | output | 16 | Data selector |
| tag_we | output | 1 | Tag word load strobe |
| ftw | output | 16 | Full tag word |
| fpr_we | output | 1 | FP register load strobe |
| fpr_idx | output | 3 | FP register index |
| fpr_data | output | 80 | FP register value |
| mxcsr_we | output | 1 | MXCSR load strobe |
| mxcsr | output | 32 | MXCSR value |
| xmm_we | output | 1 | XMM register load strobe |
| xmm_idx | output | $clog2(XMM_REGS) | XMM register index |
| xmm_data | output | 128 | XMM register value |
| done | output | 1 | Restore finished |
| exc | output | 1 | Restore aborted with an exception |
| exc_code | output | 2 | 1 undefined opcode, 2 device not available, 3 general protection |

## Verification
The assertions watch every cycle for four things. No strobe may come between a start and an exception. Done and exception must stay exclusive. Reads must be single and 16-byte aligned. Two output relations must hold: `ftop` must agree with `fsw`, and selector values must agree with the pointer width. Only the bench scenarios can show that the right bytes land in the right fields. This covers the choice between memory and initial values per header bit, the tag expansion, the XMM count in each mode, and the check priority. The bench sweeps every legal combination of enabled features, requested components, header bits, operand size and mode, and then drives each exception cause on its own.

// File: rtl/ext_state_restore.sv
module ext_state_restore #(
  parameter int          ADDR_W     = 48,
  parameter int          XMM_REGS   = 16,
  parameter logic [31:0] MXCSR_MASK = 32'h0000_FFBF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [ADDR_W-1:0]           base_addr,
  input  logic [1:0]                  req_mask,
  input  logic [63:0]                 xcr0,
  input  logic                        osxsave_en,
  input  logic                        task_switched,
  input  logic                        os64,
  input  logic                        long_mode,
  output logic                        rd_req,
  output logic [ADDR_W-1:0]           rd_addr,
  input  logic                        rd_valid,
  input  logic [127:0]                rd_data,
  output logic                        ctrl_we,
  output logic [15:0]                 fcw,
  output logic [15:0]                 fsw,
  output logic [2:0]                  ftop,
  output logic [10:0]                 fop,
  output logic                        ptr_we,
  output logic [63:0]                 fip,
  output logic [15:0]                 fcs,
  output logic [63:0]                 fdp,
  output logic [15:0]                 fds,
  output logic                        tag_we,
  output logic [15:0]                 ftw,
  output logic                        fpr_we,
  output logic [2:0]                  fpr_idx,
  output logic [79:0]                 fpr_data,
  output logic                        mxcsr_we,
  output logic [31:0]                 mxcsr,
  output logic                        xmm_we,
  output logic [$clog2(XMM_REGS)-1:0] xmm_idx,
  output logic [127:0]                xmm_data,
  output logic                        done,
  output logic                        exc,
  output logic [1:0]                  exc_code
);
  localparam int IW = $clog2(XMM_REGS);
  localparam logic [IW-1:0] XMM_LAST_L = IW'(XMM_REGS - 1);
  localparam logic [IW-1:0] XMM_LAST_S = IW'(XMM_REGS / 2 - 1);
  localparam logic [1:0] EXC_UD = 2'd1, EXC_NM = 2'd2, EXC_GP = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_HDRA, S_HDRB, S_MID, S_LOW, S_X87, S_FPR, S_TAG, S_MXW, S_XMM
  } st_t;

  st_t            st;
  logic           pend;
  logic [IW-1:0]  cnt;
  logic [ADDR_W-1:0] base_q;
  logic [63:0]    xcr0_q;
  logic           os64_q, lm_q, x87_sel, sse_sel, hdr_ext, hdr_rsv;
  logic [1:0]     hbits;
  logic [127:0]   w0, w16;
  logic [15:0]    ftw_acc;
  logic           is_rd, step;
  logic [10:0]    off;
  logic [7:0]     abr;
  logic           unused_bits;

  function automatic logic [1:0] tag_of(input logic [79:0] r, input logic valid);
    logic [14:0] e;
    logic [63:0] f;
    e = r[78:64];
    f = r[63:0];
    if (!valid)                                   tag_of = 2'b11;
    else if (e == '0 && f == '0)                  tag_of = 2'b01;
    else if (e == 15'h7FFF || e == '0 || !f[63])  tag_of = 2'b10;
    else                                          tag_of = 2'b00;
  endfunction

  assign is_rd = (st == S_HDRA) || (st == S_HDRB) || (st == S_MID) || (st == S_LOW) ||
                 (st == S_FPR && hbits[0]) || (st == S_XMM && hbits[1]);
  assign rd_req = is_rd && !pend;
  assign step   = is_rd ? (pend && rd_valid) : 1'b1;

  always_comb begin
    case (st)
      S_HDRA:  off = 11'd512;
      S_HDRB:  off = 11'd528;
      S_MID:   off = 11'd16;
      S_FPR:   off = 11'd32 + {4'd0, cnt[2:0], 4'd0};
      S_XMM:   off = 11'd160 + 11'({cnt, 4'd0});
      default: off = 11'd0;
    endcase
  end
  assign rd_addr = base_q + ADDR_W'(off);

  assign abr      = hbits[0] ? w0[39:32] : 8'h00;
  assign ctrl_we  = (st == S_X87);
  assign ptr_we   = (st == S_X87);
  assign fcw      = hbits[0] ? w0[15:0]  : 16'h037F;
  assign fsw      = hbits[0] ? w0[31:16] : 16'h0000;
  assign ftop     = fsw[13:11];
  assign fop      = hbits[0] ? w0[58:48] : 11'd0;
  assign fip      = !hbits[0] ? 64'd0 : os64_q ? w0[127:64] : {32'd0, w0[95:64]};
  assign fcs      = (hbits[0] && !os64_q) ? w0[111:96] : 16'd0;
  assign fdp      = !hbits[0] ? 64'd0 : os64_q ? w16[63:0] : {32'd0, w16[31:0]};
  assign fds      = (hbits[0] && !os64_q) ? w16[47:32] : 16'd0;
  assign tag_we   = (st == S_TAG);
  assign ftw      = ftw_acc;
  assign fpr_we   = (st == S_FPR) && step;
  assign fpr_idx  = cnt[2:0];
  assign fpr_data = hbits[0] ? rd_data[79:0] : 80'd0;
  assign mxcsr_we = (st == S_MXW);
  assign mxcsr    = w16[95:64];
  assign xmm_we   = (st == S_XMM) && step;
  assign xmm_idx  = cnt;
  assign xmm_data = hbits[1] ? rd_data : 128'd0;
  assign unused_bits = ^{w0[47:40], w0[63:59], w16[127:96]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= 1'b0; cnt <= '0; base_q <= '0; xcr0_q <= '0;
      os64_q <= 1'b0; lm_q <= 1'b0; x87_sel <= 1'b0; sse_sel <= 1'b0;
      hdr_ext <= 1'b0; hdr_rsv <= 1'b0; hbits <= 2'b00; w0 <= '0; w16 <= '0;
      ftw_acc <= 16'hFFFF; done <= 1'b0; exc <= 1'b0; exc_code <= 2'd0;
    end else begin
      done <= 1'b0;
      exc  <= 1'b0;
      if (rd_req) pend <= 1'b1;
      else if (rd_valid) pend <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q <= base_addr; xcr0_q <= xcr0; os64_q <= os64; lm_q <= long_mode;
          x87_sel <= req_mask[0] & xcr0[0];
          sse_sel <= req_mask[1] & xcr0[1];
          if (!osxsave_en)        begin exc <= 1'b1; exc_code <= EXC_UD; end
          else if (task_switched) begin exc <= 1'b1; exc_code <= EXC_NM; end
          else if (|base_addr[5:0]) begin exc <= 1'b1; exc_code <= EXC_GP; end
          else st <= S_HDRA;
        end
        S_HDRA: if (step) begin
          hbits   <= rd_data[1:0];
          hdr_ext <= |(rd_data[63:0] & ~xcr0_q);
          hdr_rsv <= |rd_data[127:64];
          st <= S_HDRB;
        end
        S_HDRB: if (step) begin
          if (hdr_ext || hdr_rsv || (|rd_data[63:0])) begin
            exc <= 1'b1; exc_code <= EXC_GP; st <= S_IDLE;
          end else if (sse_sel || (x87_sel && hbits[0])) st <= S_MID;
          else if (x87_sel) st <= S_X87;
          else begin done <= 1'b1; st <= S_IDLE; end
        end
        S_MID: if (step) begin
          w16 <= rd_data;
          if (sse_sel && (|(rd_data[95:64] & ~MXCSR_MASK))) begin
            exc <= 1'b1; exc_code <= EXC_GP; st <= S_IDLE;
          end else if (x87_sel) st <= hbits[0] ? S_LOW : S_X87;
          else st <= S_MXW;
        end
        S_LOW: if (step) begin
          w0 <= rd_data;
          st <= S_X87;
        end
        S_X87: begin
          cnt <= '0;
          st  <= S_FPR;
        end
        S_FPR: if (step) begin
          ftw_acc[{cnt[2:0], 1'b0} +: 2] <= tag_of(fpr_data, abr[cnt[2:0]]);
          if (cnt[2:0] == 3'd7) st <= S_TAG;
          else cnt <= cnt + 1'b1;
        end
        S_TAG: begin
          if (sse_sel) st <= S_MXW;
          else begin done <= 1'b1; st <= S_IDLE; end
        end
        S_MXW: begin
          cnt <= '0;
          st  <= S_XMM;
        end
        S_XMM: if (step) begin
          if (cnt == (lm_q ? XMM_LAST_L : XMM_LAST_S)) begin done <= 1'b1; st <= S_IDLE; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ext_state_restore_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic        exc,
  input logic        ctrl_we,
  input logic        ptr_we,
  input logic        tag_we,
  input logic        fpr_we,
  input logic        mxcsr_we,
  input logic        xmm_we,
  input logic        rd_req,
  input logic [3:0]  rd_addr_lo,
  input logic [15:0] fsw,
  input logic [2:0]  ftop,
  input logic [63:0] fip,
  input logic [15:0] fcs,
  input logic [63:0] fdp,
  input logic [15:0] fds
);
  logic active, wrote, any_we;
  assign any_we = ctrl_we | ptr_we | tag_we | fpr_we | mxcsr_we | xmm_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      wrote  <= 1'b0;
    end else begin
      if (done || exc) active <= 1'b0;
      else if (start) active <= 1'b1;
      if (start && !active) wrote <= 1'b0;
      else if (any_we) wrote <= 1'b1;
    end
  end

  assert_no_write_before_exc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> !wrote && !any_we);
  assert_done_exc_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && exc));
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done || exc) |=> !(done || exc));
  assert_one_strobe_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, tag_we, fpr_we, mxcsr_we, xmm_we}));
  assert_read_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr_lo == 4'd0);
  assert_single_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_top_from_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |-> ftop == fsw[13:11]);
  assert_selector_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && (fcs != 16'd0 || fds != 16'd0)) |-> (fip[63:32] == 32'd0 && fdp[63:32] == 32'd0));
endmodule

bind ext_state_restore ext_state_restore_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .exc(exc),
  .ctrl_we(ctrl_we), .ptr_we(ptr_we), .tag_we(tag_we), .fpr_we(fpr_we),
  .mxcsr_we(mxcsr_we), .xmm_we(xmm_we), .rd_req(rd_req), .rd_addr_lo(rd_addr[3:0]),
  .fsw(fsw), .ftop(ftop), .fip(fip), .fcs(fcs), .fdp(fdp), .fds(fds)
);

// File: tb/tb_ext_state_restore.sv
module tb_ext_state_restore;
  localparam int AW = 48;
  localparam logic [31:0] MASK = 32'h0000_FFBF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [1:0] req_mask = 2'b00;
  logic [63:0] xcr0 = 64'd1;
  logic osxsave_en = 1'b0, task_switched = 1'b0, os64 = 1'b0, long_mode = 1'b0;
  logic rd_req, rd_valid = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [127:0] rd_data = '0;
  logic ctrl_we, ptr_we, tag_we, fpr_we, mxcsr_we, xmm_we, done, exc;
  logic [15:0] fcw, fsw, fcs, fds, ftw;
  logic [2:0] ftop, fpr_idx;
  logic [10:0] fop;
  logic [63:0] fip, fdp;
  logic [79:0] fpr_data;
  logic [31:0] mxcsr;
  logic [3:0] xmm_idx;
  logic [127:0] xmm_data;
  logic [1:0] exc_code;

  ext_state_restore dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr), .req_mask(req_mask),
    .xcr0(xcr0), .osxsave_en(osxsave_en), .task_switched(task_switched), .os64(os64),
    .long_mode(long_mode), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .ctrl_we(ctrl_we), .fcw(fcw), .fsw(fsw), .ftop(ftop), .fop(fop),
    .ptr_we(ptr_we), .fip(fip), .fcs(fcs), .fdp(fdp), .fds(fds), .tag_we(tag_we),
    .ftw(ftw), .fpr_we(fpr_we), .fpr_idx(fpr_idx), .fpr_data(fpr_data),
    .mxcsr_we(mxcsr_we), .mxcsr(mxcsr), .xmm_we(xmm_we), .xmm_idx(xmm_idx),
    .xmm_data(xmm_data), .done(done), .exc(exc), .exc_code(exc_code)
  );

  // memory model: one cycle to accept, data one cycle later
  logic [127:0] mem [0:63];
  logic req_q = 1'b0;
  logic [5:0] idx_q = '0;
  int n_rd = 0;
  logic bad_addr = 1'b0;
  always @(posedge clk) begin
    rd_valid <= req_q;
    rd_data  <= mem[idx_q];
    req_q    <= rd_req;
    idx_q    <= 6'((rd_addr - base_addr) >> 4);
  end

  // strobe monitor, sampled on the falling edge
  int n_ctrl = 0, n_ptr = 0, n_tag = 0, n_fpr = 0, n_mx = 0, n_xmm = 0;
  logic [15:0] g_fcw, g_fsw, g_fcs, g_fds, g_ftw;
  logic [2:0] g_top;
  logic [10:0] g_fop;
  logic [63:0] g_fip, g_fdp;
  logic [31:0] g_mx;
  logic [79:0] g_fpr [0:7];
  logic [127:0] g_xmm [0:15];
  always @(negedge clk) begin
    if (rd_req) begin
      n_rd++;
      if (rd_addr[3:0] != 4'd0) bad_addr = 1'b1;
    end
    if (ctrl_we) begin n_ctrl++; g_fcw = fcw; g_fsw = fsw; g_top = ftop; g_fop = fop; end
    if (ptr_we) begin n_ptr++; g_fip = fip; g_fcs = fcs; g_fdp = fdp; g_fds = fds; end
    if (tag_we) begin n_tag++; g_ftw = ftw; end
    if (fpr_we) begin n_fpr++; g_fpr[fpr_idx] = fpr_data; end
    if (mxcsr_we) begin n_mx++; g_mx = mxcsr; end
    if (xmm_we) begin n_xmm++; g_xmm[xmm_idx] = xmm_data; end
  end

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  function automatic logic [79:0] fpval(input int k, input int seed);
    case (k % 8)
      0: fpval = 80'd0;
      1: fpval = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
      2: fpval = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000 | 64'(seed)};
      3: fpval = {1'b0, 15'h0000, 64'h1};
      4: fpval = {1'b0, 15'h1234, 64'h0000_0000_0000_00FF};
      5: fpval = {1'b1, 15'h4001, 64'hC000_0000_0000_0000};
      6: fpval = {1'b1, 15'h0000, 64'h0};
      default: fpval = {1'b0, 15'h3FFE, 64'hFFFF_0000_0000_0000 | 64'(seed)};
    endcase
  endfunction

  function automatic logic [1:0] exp_tag(input logic [79:0] v, input logic b);
    if (!b) return 2'b11;
    if (v[78:64] == 0 && v[63:0] == 0) return 2'b01;
    if (v[78:64] == 15'h7FFF || v[78:64] == 0 || !v[63]) return 2'b10;
    return 2'b00;
  endfunction

  logic [127:0] w0, w16;

  task automatic fill(input int seed, input logic [63:0] h0, h1, h2, input logic [31:0] mx);
    for (int i = 0; i < 64; i++) mem[i] = {4{32'hEEEE_0000 | 32'(i)}};
    w0  = {16'h9ABC ^ 16'(seed), 16'h4321 + 16'(seed), 32'h1357_0000 | 32'(seed),
           16'hF800 | 16'(seed * 3), 8'h00, 8'hB7 ^ 8'(seed),
           {2'b01, 3'(seed), 11'h155}, 16'h0300 | 16'(seed & 8'hFF)};
    w16 = {32'hDEAD_0000 | 32'(seed), mx, 16'h7E00 + 16'(seed), 16'hBEEF ^ 16'(seed),
           32'h2468_0000 | 32'(seed)};
    mem[0] = w0;
    mem[1] = w16;
    for (int i = 0; i < 8; i++) mem[2 + i] = {48'hABCD_EF01_2345, fpval(i + seed, seed)};
    for (int i = 0; i < 16; i++) mem[10 + i] = {32'h0F0F_0000 | 32'(i), 32'(seed), 32'hAAAA_5555 ^ 32'(i), 32'h1};
    mem[32] = {h1, h0};
    mem[33] = {64'hFFFF_FFFF_FFFF_FFFF, h2};
  endtask

  task automatic run(input logic [63:0] x0, input logic [1:0] rq, input logic [63:0] h0, h1, h2,
                     input logic o64, lm, ue, ts, input int misalign, input logic [31:0] mx,
                     input int seed);
    logic [1:0] ecode;
    logic x_sel, s_sel;
    logic [AW-1:0] base;
    int waited;
    logic got_done, got_exc;
    logic [1:0] got_code;
    logic [15:0] tw;
    base  = AW'(48'h10_0000 + 48'(seed) * 48'd1024 + 48'(misalign));
    x_sel = rq[0] & x0[0];
    s_sel = rq[1] & x0[1];
    if (!ue) ecode = 2'd1;
    else if (ts) ecode = 2'd2;
    else if (base[5:0] != 0) ecode = 2'd3;
    else if ((h0 & ~x0) != 0 || h1 != 0 || h2 != 0) ecode = 2'd3;
    else if (s_sel && (mx & ~MASK) != 0) ecode = 2'd3;
    else ecode = 2'd0;
    fill(seed, h0, h1, h2, mx);
    @(negedge clk);
    n_ctrl = 0; n_ptr = 0; n_tag = 0; n_fpr = 0; n_mx = 0; n_xmm = 0; n_rd = 0; bad_addr = 0;
    for (int i = 0; i < 8; i++) g_fpr[i] = 'x;
    for (int i = 0; i < 16; i++) g_xmm[i] = 'x;
    base_addr = base; req_mask = rq; xcr0 = x0; os64 = o64; long_mode = lm;
    osxsave_en = ue; task_switched = ts; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!(done || exc) && waited < 500) begin @(negedge clk); waited++; end
    got_done = done; got_exc = exc; got_code = exc_code;
    chk(waited < 500, "R4 restore ends", 128'(waited), 128'd0);
    chk(got_done == (ecode == 0) && got_exc == (ecode != 0), "R4 done/exc outcome",
        {got_done, got_exc}, {ecode == 0, ecode != 0});
    if (ecode != 0) begin
      chk(got_code == ecode, "R1 R2 R3 exception code", got_code, ecode);
      chk(n_ctrl + n_ptr + n_tag + n_fpr + n_mx + n_xmm == 0, "R4 no strobes on exception",
          n_ctrl + n_ptr + n_tag + n_fpr + n_mx + n_xmm, 0);
      if (!ue || ts || base[5:0] != 0) chk(n_rd == 0, "R1 no read after pre-check fail", n_rd, 0);
      return;
    end
    chk(!bad_addr, "R12 aligned reads", bad_addr, 0);
    chk(n_ctrl == (x_sel ? 1 : 0) && n_ptr == n_ctrl && n_tag == n_ctrl,
        "R11 x87 strobe counts", {n_ctrl, n_ptr, n_tag}, x_sel);
    chk(n_fpr == (x_sel ? 8 : 0), "R11 fpr count", n_fpr, x_sel ? 8 : 0);
    chk(n_mx == (s_sel ? 1 : 0), "R11 mxcsr count", n_mx, s_sel);
    chk(n_xmm == (s_sel ? (lm ? 16 : 8) : 0), "R10 xmm count", n_xmm, s_sel ? (lm ? 16 : 8) : 0);
    if (x_sel) begin
      if (h0[0]) begin
        chk(g_fcw == w0[15:0], "R5 fcw", g_fcw, w0[15:0]);
        chk(g_fsw == w0[31:16], "R5 fsw", g_fsw, w0[31:16]);
        chk(g_top == 3'(seed), "R5 top", g_top, 3'(seed));
        chk(g_fop == 11'(seed * 3), "R5 fop low 11 bits", g_fop, 11'(seed * 3));
        chk(g_fip == (o64 ? w0[127:64] : {32'd0, w0[95:64]}), "R6 fip", g_fip,
            o64 ? w0[127:64] : {32'd0, w0[95:64]});
        chk(g_fcs == (o64 ? 16'd0 : w0[111:96]), "R6 fcs", g_fcs, o64 ? 16'd0 : w0[111:96]);
        chk(g_fdp == (o64 ? w16[63:0] : {32'd0, w16[31:0]}), "R6 fdp", g_fdp,
            o64 ? w16[63:0] : {32'd0, w16[31:0]});
        chk(g_fds == (o64 ? 16'd0 : w16[47:32]), "R6 fds", g_fds, o64 ? 16'd0 : w16[47:32]);
        tw = '0;
        for (int i = 0; i < 8; i++) begin
          tw[2*i +: 2] = exp_tag(fpval(i + seed, seed), w0[32 + i]);
          chk(g_fpr[i] == fpval(i + seed, seed), "R9 fp register", g_fpr[i], fpval(i + seed, seed));
        end
        chk(g_ftw == tw, "R8 tag word", g_ftw, tw);
      end else begin
        chk(g_fcw == 16'h037F && g_fsw == 0 && g_top == 0 && g_fop == 0, "R7 init control",
            {g_fcw, g_fsw, g_top, g_fop}, {16'h037F, 16'd0, 3'd0, 11'd0});
        chk(g_fip == 0 && g_fdp == 0 && g_fcs == 0 && g_fds == 0, "R7 init pointers",
            {g_fip, g_fdp}, 0);
        chk(g_ftw == 16'hFFFF, "R7 R8 init tag", g_ftw, 16'hFFFF);
        for (int i = 0; i < 8; i++) chk(g_fpr[i] == 0, "R7 init fp register", g_fpr[i], 0);
      end
    end
    if (s_sel) begin
      chk(g_mx == mx, "R10 mxcsr", g_mx, mx);
      for (int i = 0; i < (lm ? 16 : 8); i++)
        chk(g_xmm[i] == (h0[1] ? mem[10 + i] : 128'd0), "R10 xmm register", g_xmm[i],
            h0[1] ? mem[10 + i] : 128'd0);
    end
  endtask

  initial begin
    int seed;
    seed = 1;
    repeat (3) @(negedge clk);
    chk(done == 0 && exc == 0 && rd_req == 0, "R4 reset idle", {done, exc, rd_req}, 0);
    chk(ctrl_we == 0 && fpr_we == 0 && xmm_we == 0 && mxcsr_we == 0 && tag_we == 0,
        "R4 reset no strobes", {ctrl_we, fpr_we, xmm_we, mxcsr_we, tag_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // sweep: features x request x header x operand size x mode
    for (int xs = 0; xs < 2; xs++)
      for (int rq = 0; rq < 4; rq++)
        for (int h = 0; h < 4; h++)
          for (int m = 0; m < 4; m++) begin
            if ((h & ~(xs * 2 + 1)) != 0) continue;
            run(64'(xs * 2 + 1), 2'(rq), 64'(h), 64'd0, 64'd0, m[0], m[1], 1'b1, 1'b0, 0,
                32'h1F80 | 32'(seed & 32'h3F), seed);
            seed++;
          end
    // R1 priority and alignment
    run(64'd3, 2'b11, 64'd3, 0, 0, 1'b0, 1'b0, 1'b0, 1'b1, 8, 32'h1F80, seed++);
    run(64'd3, 2'b11, 64'd3, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 8, 32'h1F80, seed++);
    run(64'd3, 2'b11, 64'd3, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 16, 32'h1F80, seed++);
    run(64'd3, 2'b11, 64'd3, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1, 32'h1F80, seed++);
    // R2 header errors
    run(64'd1, 2'b01, 64'd2, 0, 0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 32'h1F80, seed++);
    run(64'd3, 2'b11, 64'h21, 0, 0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 32'h1F80, seed++);
    run(64'd3, 2'b11, 64'd3, 64'h8000_0000_0000_0000, 0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 32'h1F80, seed++);
    run(64'd3, 2'b11, 64'd3, 0, 64'd4, 1'b0, 1'b1, 1'b1, 1'b0, 0, 32'h1F80, seed++);
    // R3 mxcsr check, also with header bit 1 clear; skipped when SSE unselected
    run(64'd3, 2'b11, 64'd1, 0, 0, 1'b1, 1'b0, 1'b1, 1'b0, 0, 32'h1FC0, seed++);
    run(64'd3, 2'b11, 64'd3, 0, 0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 32'h0001_1F80, seed++);
    run(64'd3, 2'b01, 64'd1, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 0, 32'hFFFF_FFFF, seed++);
    run(64'd1, 2'b11, 64'd1, 0, 0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 32'hFFFF_FFFF, seed++);
    // R11 request bit set but feature disabled (already swept); final normal run after errors
    run(64'd3, 2'b11, 64'd3, 0, 0, 1'b0, 1'b1, 1'b1, 1'b0, 0, 32'h0000_FFBF, seed++);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule